// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block captures interrupt requests on a small set of request lines and holds them as a pending vector for the priority logic that follows it. Each line runs in one of two capture modes chosen by a trigger-mode register. In level mode the pending bit simply mirrors the line. In edge mode a pending bit is set by a low-to-high transition and stays set until it is acknowledged.

The block remembers the previous level of every line so that it can detect transitions. The request inputs are taken as synchronous to the block clock. The trigger-mode register is written a whole vector at a time. A parameter mask fixes some of its bits: a bit that the mask clears can never be set, so that line always captures on edges. An acknowledge strobe with a line index clears a latched edge request. It leaves a level-mode line untouched, because such a line stays pending while its input is high.

Top module: `irq_req_latch`

## Requirements
- R1: While `rst` is high, the next clock clears the pending vector, the trigger-mode register and the remembered levels. As a result, a line held high across the release of reset latches in edge mode on the first clock after reset.
- R2: A line whose trigger-mode bit is 1 (level mode) has its pending bit equal to the line's input as sampled at the previous clock edge.
- R3: A line whose trigger-mode bit is 0 (edge mode) sets its pending bit one clock after the clock edge at which the input is high and the remembered level from the edge before is low.
- R4: In edge mode a low input does not clear a latched pending bit, and an input held high does not set the bit again after it has been cleared.
- R5: A write of `mode_wr_data` with `mode_wr_en` high stores `mode_wr_data & WRITABLE_MASK`. With the default mask 8'hF8, lines 0 to 2 always read 0, which is edge mode.
- R6: `mode_rd` shows a write one clock after it. Capture uses the mode that was stored before the clock edge, so a new mode governs capture from the following edge onward.
- R7: `ack_valid` high with `ack_line` = k clears pending bit k at the next edge when line k is in edge mode. No other line is affected.
- R8: An acknowledge of a level-mode line has no effect on its pending bit.
- R9: When an acknowledge and a rising edge arrive on the same edge-mode line at the same clock edge, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | LINES | Raw request lines, synchronous to clk |
| mode_wr_en | input | 1 | Write strobe for the trigger-mode register |
| mode_wr_data | input | LINES | Trigger-mode write value (1 = level, 0 = edge) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | IDXW | Index of the line being acknowledged |
| pending | output | LINES | Registered pending-request vector |
| mode_rd | output | LINES | Registered trigger-mode readback |

## Verification
The hardest situations to reach are the ones where several causes act on the same line in the same cycle. One is an acknowledge that meets a fresh rising edge. Another is a change of trigger mode while a line is held high, where the remembered level, not the new mode, decides whether the line latches. Neither can be seen directly at the ports. To reach them, the bench writes every possible trigger-mode value in turn. After each write it runs a stretch of pseudo-random request and acknowledge traffic, so that mode changes land on lines in every state. A few directed sequences place an acknowledge and a rising edge on the same line in the same cycle.

// File: rtl/irq_req_latch_pkg.sv
package irq_req_latch_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  // Next pending value of one line from its mode, current state and input.
  function automatic logic capture_next(
    input trig_e mode,
    input logic  cur,
    input logic  lvl,
    input logic  last_lvl,
    input logic  clr
  );
    logic held;
    if (mode == TRIG_LEVEL) begin
      return lvl;
    end
    held = cur & ~clr;
    return held | (lvl & ~last_lvl);
  endfunction

endpackage

// File: rtl/irq_trig_reg.sv
module irq_trig_reg #(
  parameter int          LINES         = 8,
  parameter logic [LINES-1:0] WRITABLE_MASK = 8'hF8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [LINES-1:0] wr_data,
  output logic [LINES-1:0] mode_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (wr_en) begin
      mode_q <= wr_data & WRITABLE_MASK;
    end
  end

endmodule

// File: rtl/irq_ack_decode.sv
module irq_ack_decode #(
  parameter int LINES = 8,
  localparam int IDXW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             ack_valid,
  input  logic [IDXW-1:0]  ack_line,
  output logic [LINES-1:0] ack_hot
);

  for (genvar g = 0; g < LINES; g++) begin : g_dec
    assign ack_hot[g] = ack_valid && (ack_line == IDXW'(g));
  end

endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_req_latch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode_level,
  input  logic req,
  input  logic clr,
  output logic pend_q
);

  logic  last_q;
  trig_e mode;

  assign mode = mode_level ? TRIG_LEVEL : TRIG_EDGE;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      pend_q <= capture_next(mode, pend_q, req, last_q, clr);
      last_q <= req;
    end
  end

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int               LINES         = 8,
  parameter logic [LINES-1:0] WRITABLE_MASK = 8'hF8,
  localparam int              IDXW          = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] req_in,
  input  logic             mode_wr_en,
  input  logic [LINES-1:0] mode_wr_data,
  input  logic             ack_valid,
  input  logic [IDXW-1:0]  ack_line,
  output logic [LINES-1:0] pending,
  output logic [LINES-1:0] mode_rd
);

  logic [LINES-1:0] mode_q;
  logic [LINES-1:0] ack_hot;

  irq_trig_reg #(
    .LINES         (LINES),
    .WRITABLE_MASK (WRITABLE_MASK)
  ) u_trig (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (mode_wr_en),
    .wr_data (mode_wr_data),
    .mode_q  (mode_q)
  );

  irq_ack_decode #(
    .LINES (LINES)
  ) u_ack (
    .ack_valid (ack_valid),
    .ack_line  (ack_line),
    .ack_hot   (ack_hot)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    irq_line_cell u_cell (
      .clk        (clk),
      .rst        (rst),
      .mode_level (mode_q[g]),
      .req        (req_in[g]),
      .clr        (ack_hot[g]),
      .pend_q     (pending[g])
    );
  end

  assign mode_rd = mode_q;

endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
  parameter int               LINES         = 8,
  parameter logic [LINES-1:0] WRITABLE_MASK = 8'hF8,
  localparam int              IDXW          = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic [LINES-1:0] req_in,
  input logic             mode_wr_en,
  input logic [LINES-1:0] mode_wr_data,
  input logic             ack_valid,
  input logic [IDXW-1:0]  ack_line,
  input logic [LINES-1:0] pending,
  input logic [LINES-1:0] mode_rd
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) === 1'b1 |-> (pending == '0 && mode_rd == '0));

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_rd & ~WRITABLE_MASK) == '0);

  assert_write_seen_R6: assert property (@(posedge clk) disable iff (rst)
    $past(mode_wr_en) && !$past(rst) |-> mode_rd == ($past(mode_wr_data) & WRITABLE_MASK));

  for (genvar g = 0; g < LINES; g++) begin : g_prop
    assert_level_follow_R2: assert property (@(posedge clk) disable iff (rst)
      $past(mode_rd[g]) && !$past(rst) |-> pending[g] == $past(req_in[g]));

    assert_edge_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !$past(mode_rd[g]) && $past(pending[g]) &&
      !($past(ack_valid) && $past(ack_line) == IDXW'(g)) |-> pending[g]);

    assert_ack_clear_R7: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && !$past(mode_rd[g]) && $past(ack_valid) &&
      $past(ack_line) == IDXW'(g) && !$past(req_in[g]) |-> !pending[g]);
  end

endmodule

bind irq_req_latch irq_req_latch_chk #(
  .LINES         (LINES),
  .WRITABLE_MASK (WRITABLE_MASK)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_in       (req_in),
  .mode_wr_en   (mode_wr_en),
  .mode_wr_data (mode_wr_data),
  .ack_valid    (ack_valid),
  .ack_line     (ack_line),
  .pending      (pending),
  .mode_rd      (mode_rd)
);

// File: tb/irq_req_latch_bench.sv
module irq_req_latch_bench;

  localparam int         LINES = 8;
  localparam int         IDXW  = 3;
  localparam logic [7:0] MASK  = 8'hF8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LINES-1:0] req_in = '0;
  logic             mode_wr_en = 1'b0;
  logic [LINES-1:0] mode_wr_data = '0;
  logic             ack_valid = 1'b0;
  logic [IDXW-1:0]  ack_line = '0;
  logic [LINES-1:0] pending;
  logic [LINES-1:0] mode_rd;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [7:0]  m_pend = '0;
  logic [7:0]  m_last = '0;
  logic [7:0]  m_mode = '0;
  logic [15:0] lfsr   = 16'hACE1;

  always #10 clk = ~clk;

  irq_req_latch #(.LINES(LINES), .WRITABLE_MASK(MASK)) u_irq_req_latch (
    .clk          (clk),
    .rst          (rst),
    .req_in       (req_in),
    .mode_wr_en   (mode_wr_en),
    .mode_wr_data (mode_wr_data),
    .ack_valid    (ack_valid),
    .ack_line     (ack_line),
    .pending      (pending),
    .mode_rd      (mode_rd)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, update model at the edge, compare at next negedge.
  task automatic step(input logic [7:0] r, input bit we, input logic [7:0] wd,
                      input bit av, input logic [2:0] al);
    logic [7:0] np;
    req_in = r; mode_wr_en = we; mode_wr_data = wd; ack_valid = av; ack_line = al;
    @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      if (rst) np[i] = 1'b0;
      else if (m_mode[i]) np[i] = r[i];
      else np[i] = (m_pend[i] & ~(av && al == 3'(i))) | (r[i] & ~m_last[i]);
    end
    if (rst) begin
      m_last = '0; m_mode = '0;
    end else begin
      m_last = r;
      if (we) m_mode = wd & MASK;
    end
    m_pend = np;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (pending[i] !== m_pend[i]) begin
        if (m_mode[i] && !(we && wd[i])) check(1'b0, "R2 level capture", pending, m_pend);
        else if (av && al == 3'(i)) check(1'b0, "R7 edge ack", pending, m_pend);
        else check(1'b0, "R3 edge capture", pending, m_pend);
      end else begin
        checks++;
      end
    end
    check(mode_rd === m_mode, "R6 mode readback", mode_rd, m_mode);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    step(8'hFF, 1'b1, 8'hFF, 1'b1, 3'd0);
    step(8'hFF, 1'b0, 8'h00, 1'b0, 3'd0);
    check(pending === 8'h00 && mode_rd === 8'h00, "R1 reset state", pending, 8'h00);
    rst = 1'b0;
    // R1: lines high through reset release latch on the first edge in edge mode
    step(8'h05, 1'b0, 8'h00, 1'b0, 3'd0);
    check(pending === 8'h05, "R1 remembered level cleared", pending, 8'h05);
    // R4: low input keeps latched request
    step(8'h00, 1'b0, 8'h00, 1'b0, 3'd0);
    check(pending === 8'h05, "R4 low keeps latch", pending, 8'h05);
    // R7: ack line 2 clears only it
    step(8'h00, 1'b0, 8'h00, 1'b1, 3'd2);
    check(pending === 8'h01, "R7 ack clears one line", pending, 8'h01);
    // R4: held high after ack does not relatch
    step(8'h10, 1'b0, 8'h00, 1'b0, 3'd0);
    step(8'h10, 1'b0, 8'h00, 1'b1, 3'd4);
    step(8'h10, 1'b0, 8'h00, 1'b0, 3'd0);
    check(pending === 8'h01, "R4 held high no relatch", pending, 8'h01);
    // R5: masked write
    step(8'h00, 1'b1, 8'hFF, 1'b0, 3'd0);
    check(mode_rd === 8'hF8, "R5 masked bits stay edge", mode_rd, 8'hF8);
    // R2 and R8: level line follows input, ack ignored
    step(8'h20, 1'b0, 8'h00, 1'b0, 3'd0);
    step(8'h20, 1'b0, 8'h00, 1'b1, 3'd5);
    check(pending[5] === 1'b1, "R8 level ack ignored", pending, m_pend);
    step(8'h00, 1'b0, 8'h00, 1'b0, 3'd0);
    check(pending[5] === 1'b0, "R2 level low clears", pending, m_pend);
    // R9: ack and rising edge collide on edge-mode line 1
    step(8'h00, 1'b1, 8'h00, 1'b0, 3'd0);
    step(8'h02, 1'b0, 8'h00, 1'b0, 3'd0);
    step(8'h00, 1'b0, 8'h00, 1'b0, 3'd0);
    step(8'h02, 1'b0, 8'h00, 1'b1, 3'd1);
    check(pending[1] === 1'b1, "R9 edge wins over ack", pending, m_pend);
    // R6: mode written while line high takes effect after the edge
    step(8'h80, 1'b1, 8'h80, 1'b0, 3'd0);
    check(mode_rd === 8'h80, "R6 write visible next cycle", mode_rd, 8'h80);
    // Sweep every mode value with pseudo-random traffic
    for (int mv = 0; mv < 256; mv++) begin
      step(lfsr[7:0], 1'b1, 8'(mv), lfsr[8], lfsr[11:9]);
      for (int k = 0; k < 14; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[7:0] & lfsr[15:8], 1'b0, 8'h00, lfsr[3], lfsr[6:4]);
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule